// File: doc/BRIEF.md
# Ethernet Receive Error Status Handler

This block manages error conditions in the receive path of an Ethernet MAC. It follows frame activity through start-of-frame and end-of-frame strobes, a receive FIFO overrun flag and a "free descriptor available" level. On a clean end of frame it closes the current descriptor with the last-in-frame bit. On an overrun it closes the descriptor with both the overrun and last bits set, counts the frame as discarded, and then ignores activity until the next frame starts.

When a frame starts and no descriptor is free, the frame is dropped and counted, a busy event is raised, and the queue is halted. While the queue is halted, every further frame start counts as another discarded frame and produces no descriptor activity. Reception resumes only after software writes a one to the halt bit. Event flags are sticky and are cleared by writing one to them. The discarded-frame counter saturates and is cleared by a register write.

Top module: `rx_err_handler`

## Requirements
- R1: After reset the counter is 0, both event flags and the halt flag are 0, no write-back is issued and the block is not hunting.
- R2: A frame started while not halted with `bd_free`=1 and then ended by `eof` gives a one-cycle write-back with `wb_overrun`=0 and `wb_last`=1, sets `ev_rxf`, and leaves the counter unchanged.
- R3: `ovf` during a frame gives a write-back with `wb_overrun`=1 and `wb_last`=1, adds one to the counter and sets `ev_rxf`; if `eof` arrives in the same cycle, the overrun takes precedence.
- R4: After an overrun, `hunting` is 1 and `eof` and `ovf` are ignored (no write-back and no count) until the next `sof`, which starts a normal frame and clears `hunting`.
- R5: `sof` while not halted with `bd_free`=0 drops the frame: no write-back, `ev_busy` set, the counter incremented and `q_halted` set; the `eof` of that frame is ignored.
- R6: While `q_halted`=1, each `sof` adds one to the counter and produces no write-back, whatever `bd_free` is.
- R7: A register write to address 1 with data bit 0 set clears `q_halted`; a write with bit 0 clear does not. After the clear, a frame is received normally.
- R8: The counter saturates at all ones.
- R9: A register write to address 2 clears the counter, and the clear takes precedence over an increment in the same cycle.
- R10: A register write to address 0 clears `ev_rxf` where data bit 0 is 1 and `ev_busy` where data bit 1 is 1; zero bits have no effect, and a new event in the same cycle wins over the clear.
- R11: `ovf` or `eof` outside a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| ovf | input | 1 | Receive FIFO overrun strobe |
| bd_free | input | 1 | A free receive descriptor is available |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 events, 1 halt, 2 counter clear |
| reg_wdata | input | 32 | Register write data |
| wb_valid | output | 1 | Descriptor status write-back strobe |
| wb_overrun | output | 1 | Overrun status bit for the descriptor |
| wb_last | output | 1 | Last-in-frame status bit for the descriptor |
| ev_rxf | output | 1 | Sticky frame-received event |
| ev_busy | output | 1 | Sticky busy event |
| q_halted | output | 1 | Queue halted for lack of buffers |
| hunting | output | 1 | Waiting for the next frame after an overrun |
| drop_cnt | output | CNT_W | Discarded-frame counter |

## Verification
The situation that is hardest to reach from the ports is counter saturation while the queue is halted, which at full width would need billions of frames. The bench instantiates the block with a 4-bit counter, stalls the queue with a busy frame and then issues a run of frame starts past the ceiling. The counter clear arriving in the same cycle as a halted-frame increment, and an event arriving in the same cycle as its write-one-to-clear, are produced by driving the register write and the frame strobe together.

// File: rtl/rx_err_handler.sv
module rx_err_handler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             eof,
  input  logic             ovf,
  input  logic             bd_free,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             wb_valid,
  output logic             wb_overrun,
  output logic             wb_last,
  output logic             ev_rxf,
  output logic             ev_busy,
  output logic             q_halted,
  output logic             hunting,
  output logic [CNT_W-1:0] drop_cnt
);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_HUNT} st_t;
  st_t st;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  wire in_frame  = (st == S_RECV);
  wire can_start = sof && !in_frame;
  wire accept    = can_start && !q_halted && bd_free;
  wire busy_hit  = can_start && !q_halted && !bd_free;
  wire halt_drop = can_start && q_halted;
  wire ovr_hit   = in_frame && ovf;
  wire eof_hit   = in_frame && eof && !ovf;
  wire cnt_inc   = ovr_hit || busy_hit || halt_drop;

  wire wr_ev   = reg_we && (reg_addr == 2'd0);
  wire wr_halt = reg_we && (reg_addr == 2'd1) && reg_wdata[0];
  wire wr_clr  = reg_we && (reg_addr == 2'd2);

  assign hunting = (st == S_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wb_valid   <= 1'b0;
      wb_overrun <= 1'b0;
      wb_last    <= 1'b0;
      ev_rxf     <= 1'b0;
      ev_busy    <= 1'b0;
      q_halted   <= 1'b0;
      drop_cnt   <= '0;
    end else begin
      if (can_start)    st <= accept ? S_RECV : S_IDLE;
      else if (ovr_hit) st <= S_HUNT;
      else if (eof_hit) st <= S_IDLE;

      wb_valid   <= ovr_hit || eof_hit;
      wb_overrun <= ovr_hit;
      wb_last    <= ovr_hit || eof_hit;

      ev_rxf  <= (ev_rxf  && !(wr_ev && reg_wdata[0])) || ovr_hit || eof_hit;
      ev_busy <= (ev_busy && !(wr_ev && reg_wdata[1])) || busy_hit;

      if (busy_hit)     q_halted <= 1'b1;
      else if (wr_halt) q_halted <= 1'b0;

      if (wr_clr)                             drop_cnt <= '0;
      else if (cnt_inc && drop_cnt != CNT_MAX) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  // R3: overrun inside a frame closes the descriptor with both bits
  a_r3_ovr_close: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECV && ovf) |=> (wb_valid && wb_overrun && wb_last && hunting));

  // R4: hunting ignores everything except a frame start
  a_r4_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && !sof) |=> (!wb_valid && hunting));

  // R5: a start without a free descriptor halts and flags busy
  a_r5_busy_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && sof && !q_halted && !bd_free) |=> (q_halted && ev_busy && !wb_valid));

  // R6/R7: halt holds until the halt bit is written with one
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_halted && !(reg_we && reg_addr == 2'd1 && reg_wdata[0])) |=> q_halted);

  // R8: saturation
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == CNT_MAX && !(reg_we && reg_addr == 2'd2)) |=> (drop_cnt == CNT_MAX));

  // R2: every write-back carries the last-in-frame bit
  a_r2_wb_last: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_last && ev_rxf));

endmodule

// File: tb/tb_rx_err_handler.sv
module tb_rx_err_handler;
  localparam int CW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, eof = 0, ovf = 0, bd_free = 1, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic wb_valid, wb_overrun, wb_last, ev_rxf, ev_busy, q_halted, hunting;
  logic [CW-1:0] drop_cnt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rx_err_handler #(.CNT_W(CW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); sof = 0; eof = 0; ovf = 0; reg_we = 0; endtask
  task automatic p_sof(); sof = 1; step(); endtask
  task automatic p_eof(); eof = 1; step(); endtask
  task automatic p_ovf(); ovf = 1; step(); endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic t_reset();
    chk("R1 cnt", drop_cnt, 0); chk("R1 rxf", ev_rxf, 0); chk("R1 busy", ev_busy, 0);
    chk("R1 halt", q_halted, 0); chk("R1 wb", wb_valid, 0); chk("R1 hunt", hunting, 0);
  endtask

  task automatic t_normal();
    bd_free = 1; p_sof(); chk("R2 no wb at sof", wb_valid, 0);
    p_eof();
    chk("R2 wb", wb_valid, 1); chk("R2 ov", wb_overrun, 0); chk("R2 last", wb_last, 1);
    chk("R2 rxf", ev_rxf, 1); chk("R2 cnt", drop_cnt, 0);
    step(); chk("R2 wb one cycle", wb_valid, 0);
  endtask

  task automatic t_w1c();
    wr(2'd0, 32'h2); chk("R10 zero bit kept", ev_rxf, 1);
    wr(2'd0, 32'h1); chk("R10 cleared", ev_rxf, 0);
  endtask

  task automatic t_overrun();
    p_sof(); ovf = 1; eof = 1; step();
    chk("R3 wb", wb_valid, 1); chk("R3 ov", wb_overrun, 1); chk("R3 last", wb_last, 1);
    chk("R3 cnt", drop_cnt, 1); chk("R3 rxf", ev_rxf, 1); chk("R4 hunting", hunting, 1);
  endtask

  task automatic t_hunt();
    p_eof(); chk("R4 eof ignored", wb_valid, 0);
    p_ovf(); chk("R4 ovf ignored wb", wb_valid, 0); chk("R4 ovf ignored cnt", drop_cnt, 1);
    chk("R4 still hunting", hunting, 1);
    p_sof(); chk("R4 hunt exit", hunting, 0);
    p_eof(); chk("R4 frame after hunt", wb_valid, 1); chk("R4 no ov", wb_overrun, 0);
  endtask

  task automatic t_idle();
    p_ovf(); chk("R11 ovf idle wb", wb_valid, 0); chk("R11 ovf idle cnt", drop_cnt, 1);
    p_eof(); chk("R11 eof idle", wb_valid, 0);
  endtask

  task automatic t_busy();
    bd_free = 0; p_sof();
    chk("R5 halt", q_halted, 1); chk("R5 busy", ev_busy, 1);
    chk("R5 cnt", drop_cnt, 2); chk("R5 no wb", wb_valid, 0);
    p_eof(); chk("R5 eof ignored", wb_valid, 0);
  endtask

  task automatic t_halted();
    bd_free = 1;
    for (int i = 0; i < 3; i++) begin
      p_sof(); chk("R6 no wb sof", wb_valid, 0);
      p_eof(); chk("R6 no wb eof", wb_valid, 0);
    end
    chk("R6 cnt", drop_cnt, 5); chk("R6 still halted", q_halted, 1);
  endtask

  task automatic t_resume();
    wr(2'd1, 32'h0); chk("R7 bit0 zero keeps halt", q_halted, 1);
    wr(2'd1, 32'h1); chk("R7 halt cleared", q_halted, 0);
    p_sof(); p_eof(); chk("R7 frame received", wb_valid, 1); chk("R7 cnt", drop_cnt, 5);
  endtask

  task automatic t_sat();
    bd_free = 0; p_sof(); bd_free = 1;
    chk("R5 halted again", q_halted, 1);
    for (int i = 0; i < 12; i++) p_sof();
    chk("R8 saturated", drop_cnt, 15);
  endtask

  task automatic t_clear();
    reg_we = 1; reg_addr = 2'd2; reg_wdata = 0; sof = 1; step();
    chk("R9 clear wins", drop_cnt, 0);
    p_sof(); chk("R9 counts after clear", drop_cnt, 1);
    wr(2'd1, 32'h1); wr(2'd0, 32'h3);
    chk("R10 busy cleared", ev_busy, 0); chk("R10 rxf cleared", ev_rxf, 0);
    p_sof();
    eof = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h1; step();
    chk("R10 set wins", ev_rxf, 1); chk("R2 wb with clear", wb_valid, 1);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; step();
    t_reset(); t_normal(); t_w1c(); t_overrun(); t_hunt(); t_idle();
    t_busy(); t_halted(); t_resume(); t_sat(); t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule